// File: doc/BRIEF.md
# Tagged Zeroing Store Unit

This unit executes one store-tag-and-zero instruction at a time. It takes a 32-bit instruction word over a valid/ready input stream and decodes the opcode and the addressing mode. It then reads a base value and a data value through a register-read port, where register index 31 stands for the stack pointer. The unit forms the access address and checks that address for 16-byte alignment. When the checks pass, it issues two zero-fill writes over a valid/ready memory port: the first to the granule at the access address and the second to the granule 16 bytes above it. Both writes carry the same 4-bit allocation tag.

Three modes are supported: pre-index, post-index and plain signed offset. The immediate is scaled by the 16-byte granule size. When the mode calls for it, the unit reports the updated base address on a writeback port. An alignment problem, or an encoding the unit does not handle, ends the operation with a one-cycle status pulse in place of any memory traffic.

Back-pressure rules:
- `in_ready` is high only while the unit is idle, so a new word is taken only after the previous operation has reported.
- On the memory side, `mem_valid` stays high and `mem_addr`, `mem_tag` and `mem_wdata` stay constant until `mem_ready` is sampled high.
- The memory port may stall for any number of cycles.

Top module: `tagzero_store_unit`

## Requirements
- R1: A word is handled only when bits 31:21 equal 11011001111 and bits 11:10 are not 00. Otherwise `undef` pulses for one cycle and there is no memory write and no writeback.
- R2: The offset is imm9 (bits 20:12) sign-extended and multiplied by 16, which covers -4096 to +4080.
- R3: Bits 11:10 select the mode. For 11 (pre-index) and 10 (signed offset) the access address is base plus offset. For 01 (post-index) the access address is the unmodified base.
- R4: Modes 11 and 01 raise `wb_valid` with `wb_idx` equal to the base index (bits 9:5) and `wb_value` equal to base plus offset. Mode 10 raises no writeback.
- R5: A base index (bits 9:5) or a data index (bits 4:0) of 31 reads `sp_val` instead of the register port.
- R6: When the base index is 31 and the stack pointer value is not a multiple of 16, `fault_sp` pulses and there is no write and no writeback. This check takes priority over R7.
- R7: An access address that is not a multiple of 16 makes `fault_align` pulse, with no write and no writeback.
- R8: A successful operation issues exactly two writes, in order: first the access address, then the access address plus 16. Both writes carry all-zero data and a tag equal to bits 59:56 of the data value.
- R9: `in_ready` is high only when the unit is idle. While `mem_valid` is high and `mem_ready` is low, the write's address, tag and data hold steady.
- R10: `done` pulses for one cycle, in the cycle after the second write is accepted. Any writeback appears in that same cycle, and at most one of `done`, `undef`, `fault_sp` and `fault_align` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit idle, word will be taken |
| in_word | input | 32 | Instruction word |
| rd_base_idx | output | 5 | Register index for the base read |
| rd_base_val | input | 64 | Register value for `rd_base_idx` (ignored for 31) |
| rd_data_idx | output | 5 | Register index for the data read |
| rd_data_val | input | 64 | Register value for `rd_data_idx` (ignored for 31) |
| sp_val | input | 64 | Stack pointer value |
| mem_valid | output | 1 | Granule write offered |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 64 | Granule byte address |
| mem_tag | output | 4 | Allocation tag for the granule |
| mem_wdata | output | 128 | Granule data (all zero) |
| wb_valid | output | 1 | Base register update |
| wb_idx | output | 5 | Register to update (31 means stack pointer) |
| wb_value | output | 64 | New base value |
| done | output | 1 | Operation completed |
| undef | output | 1 | Word not handled |
| fault_sp | output | 1 | Misaligned stack pointer base |
| fault_align | output | 1 | Misaligned access address |

## Verification
A word accepted at edge E0 has its registers read in the cycle that follows. A status pulse (`undef`, `fault_sp` or `fault_align`) is due in the cycle after E1, and in the same cycle the first granule write is offered instead when the checks pass. Each granule write stays on the port for as many cycles as the bench holds `mem_ready` low, plus one. `done` and any writeback appear in the cycle after the second acceptance, and `in_ready` returns one cycle after that. The bench advances with the design one negative edge at a time. At every negative edge it compares all outputs against values it has worked out from the instruction fields and its own register model, so any pulse that comes early, comes late or is missing is caught at the cycle where it goes wrong.

// File: rtl/tzs_pkg.sv
package tzs_pkg;
  localparam int IMM_W = 9;
  localparam int IDX_W = 5;
  localparam int WORD_W = 32;
  localparam logic [10:0] OPC_MATCH = 11'b11011001111;
  localparam logic [IDX_W-1:0] SP_IDX = '1;

  // mode encoding equals instruction bits 11:10
  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_POST = 2'b01,
    MODE_OFFS = 2'b10,
    MODE_PRE  = 2'b11
  } mode_e;

  typedef struct packed {
    logic             legal;
    mode_e            mode;
    logic [IMM_W-1:0] imm;
    logic [IDX_W-1:0] base_idx;
    logic [IDX_W-1:0] data_idx;
  } dec_t;

  typedef enum logic [2:0] {
    S_IDLE, S_EXEC, S_REPORT, S_WR0, S_WR1, S_FIN
  } state_e;

  typedef enum logic [1:0] {
    RPT_UNDEF, RPT_SP, RPT_ALIGN
  } rpt_e;
endpackage

// File: rtl/tzs_decode.sv
module tzs_decode
  import tzs_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output dec_t              dec
);
  always_comb begin
    dec.mode     = mode_e'(word[11:10]);
    dec.imm      = word[20:12];
    dec.base_idx = word[9:5];
    dec.data_idx = word[4:0];
    dec.legal    = (word[31:21] == OPC_MATCH) && (word[11:10] != 2'b00);
  end
endmodule

// File: rtl/tzs_agen.sv
module tzs_agen
  import tzs_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int GRAN_LOG2 = 4
) (
  input  mode_e             mode,
  input  logic [IMM_W-1:0]  imm,
  input  logic              base_is_sp,
  input  logic [ADDR_W-1:0] base_val,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] upd_addr,
  output logic              wb_en,
  output logic              sp_misalign,
  output logic              misalign
);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset      = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm} << GRAN_LOG2;
    upd_addr    = base_val + offset;
    acc_addr    = (mode == MODE_POST) ? base_val : upd_addr;
    wb_en       = (mode != MODE_OFFS);
    sp_misalign = base_is_sp && (base_val[GRAN_LOG2-1:0] != '0);
    misalign    = (acc_addr[GRAN_LOG2-1:0] != '0);
  end
endmodule

// File: rtl/tagzero_store_unit.sv
module tagzero_store_unit
  import tzs_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int GRAN_LOG2 = 4,
  parameter int TAG_W     = 4,
  parameter int TAG_LSB   = 56,
  localparam int GRAN_BYTES = 1 << GRAN_LOG2,
  localparam int DATA_W     = 8 * GRAN_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic [IDX_W-1:0]  rd_base_idx,
  input  logic [ADDR_W-1:0] rd_base_val,
  output logic [IDX_W-1:0]  rd_data_idx,
  input  logic [ADDR_W-1:0] rd_data_val,
  input  logic [ADDR_W-1:0] sp_val,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [TAG_W-1:0]  mem_tag,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [ADDR_W-1:0] wb_value,
  output logic              done,
  output logic              undef,
  output logic              fault_sp,
  output logic              fault_align
);
  state_e            state_q;
  logic [WORD_W-1:0] word_q;
  logic [ADDR_W-1:0] acc_q, upd_q;
  logic [TAG_W-1:0]  tag_q;
  logic              wb_en_q;
  rpt_e              rpt_q;

  dec_t              dec;
  logic              base_is_sp;
  logic [ADDR_W-1:0] base_val, data_val;
  logic [ADDR_W-1:0] acc_addr, upd_addr;
  logic              wb_en, sp_misalign, misalign;

  tzs_decode u_decode (
    .word (word_q),
    .dec  (dec)
  );

  assign base_is_sp = (dec.base_idx == SP_IDX);
  assign base_val   = base_is_sp ? sp_val : rd_base_val;
  assign data_val   = (dec.data_idx == SP_IDX) ? sp_val : rd_data_val;

  tzs_agen #(
    .ADDR_W    (ADDR_W),
    .GRAN_LOG2 (GRAN_LOG2)
  ) u_agen (
    .mode        (dec.mode),
    .imm         (dec.imm),
    .base_is_sp  (base_is_sp),
    .base_val    (base_val),
    .acc_addr    (acc_addr),
    .upd_addr    (upd_addr),
    .wb_en       (wb_en),
    .sp_misalign (sp_misalign),
    .misalign    (misalign)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      word_q  <= '0;
      acc_q   <= '0;
      upd_q   <= '0;
      tag_q   <= '0;
      wb_en_q <= 1'b0;
      rpt_q   <= RPT_UNDEF;
    end else begin
      unique case (state_q)
        S_IDLE: if (in_valid) begin
          word_q  <= in_word;
          state_q <= S_EXEC;
        end
        S_EXEC: begin
          acc_q   <= acc_addr;
          upd_q   <= upd_addr;
          tag_q   <= data_val[TAG_LSB +: TAG_W];
          wb_en_q <= wb_en;
          if (!dec.legal) begin
            rpt_q <= RPT_UNDEF;  state_q <= S_REPORT;
          end else if (sp_misalign) begin
            rpt_q <= RPT_SP;     state_q <= S_REPORT;
          end else if (misalign) begin
            rpt_q <= RPT_ALIGN;  state_q <= S_REPORT;
          end else begin
            state_q <= S_WR0;
          end
        end
        S_REPORT: state_q <= S_IDLE;
        S_WR0:    if (mem_ready) state_q <= S_WR1;
        S_WR1:    if (mem_ready) state_q <= S_FIN;
        S_FIN:    state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign in_ready    = (state_q == S_IDLE);
  assign rd_base_idx = dec.base_idx;
  assign rd_data_idx = dec.data_idx;
  assign mem_valid   = (state_q == S_WR0) || (state_q == S_WR1);
  assign mem_addr    = (state_q == S_WR1) ? acc_q + ADDR_W'(GRAN_BYTES) : acc_q;
  assign mem_tag     = tag_q;
  assign mem_wdata   = '0;
  assign done        = (state_q == S_FIN);
  assign wb_valid    = done && wb_en_q;
  assign wb_idx      = dec.base_idx;
  assign wb_value    = upd_q;
  assign undef       = (state_q == S_REPORT) && (rpt_q == RPT_UNDEF);
  assign fault_sp    = (state_q == S_REPORT) && (rpt_q == RPT_SP);
  assign fault_align = (state_q == S_REPORT) && (rpt_q == RPT_ALIGN);

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_tag)));

  // R8
  second_gran_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !done && $rose(mem_valid)) |=>
      (mem_valid && mem_addr == $past(mem_addr) + ADDR_W'(GRAN_BYTES)));

  // R10
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_valid && mem_ready));

  // R10
  one_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, undef, fault_sp, fault_align}));

  // R7
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (undef || fault_sp || fault_align) |=> (!mem_valid && !wb_valid && in_ready));

  // R4
  wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done);

  // R9
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!mem_valid && !done));
endmodule

// File: tb/tagzero_store_unit_tb.sv
`timescale 1ns/1ps
module tagzero_store_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_word = '0;
  logic [4:0]   rd_base_idx, rd_data_idx;
  logic [63:0]  rd_base_val, rd_data_val;
  logic [63:0]  sp_val = '0;
  logic         mem_valid;
  logic         mem_ready = 1'b0;
  logic [63:0]  mem_addr;
  logic [3:0]   mem_tag;
  logic [127:0] mem_wdata;
  logic         wb_valid;
  logic [4:0]   wb_idx;
  logic [63:0]  wb_value;
  logic         done, undef, fault_sp, fault_align;

  int checks = 0;
  int failures = 0;
  logic [63:0] gpr [0:31];

  always #2 clk = ~clk;

  always_comb begin
    rd_base_val = gpr[rd_base_idx];
    rd_data_val = gpr[rd_data_idx];
  end

  tagzero_store_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .rd_base_idx(rd_base_idx), .rd_base_val(rd_base_val),
    .rd_data_idx(rd_data_idx), .rd_data_val(rd_data_val), .sp_val(sp_val),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_tag(mem_tag), .mem_wdata(mem_wdata), .wb_valid(wb_valid),
    .wb_idx(wb_idx), .wb_value(wb_value), .done(done), .undef(undef),
    .fault_sp(fault_sp), .fault_align(fault_align)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] enc(input logic [8:0] imm, input logic [1:0] mode,
                                      input logic [4:0] n, input logic [4:0] t);
    return {11'b11011001111, imm, mode, n, t};
  endfunction

  task automatic quiet(input string req);
    chk({req, " mem_valid"}, 128'(mem_valid), 0);
    chk({req, " status"}, 128'({done, undef, fault_sp, fault_align, wb_valid}), 0);
  endtask

  // kind: 0 ok, 1 undef, 2 sp fault, 3 align fault
  task automatic run_op(input logic [31:0] w, input int st0, input int st1);
    logic [1:0]  mode = w[11:10];
    logic [4:0]  n = w[9:5];
    logic [4:0]  t = w[4:0];
    logic [63:0] base, data, off, sum, acc;
    int kind;
    base = (n == 31) ? sp_val : gpr[n];
    data = (t == 31) ? sp_val : gpr[t];
    off  = 64'(signed'(w[20:12])) * 64'd16;
    sum  = base + off;
    acc  = (mode == 2'b01) ? base : sum;
    if (w[31:21] != 11'b11011001111 || mode == 2'b00) kind = 1;
    else if (n == 31 && base[3:0] != 0) kind = 2;
    else if (acc[3:0] != 0) kind = 3;
    else kind = 0;

    @(negedge clk);
    chk("R9 in_ready idle", 128'(in_ready), 1);
    in_valid = 1'b1; in_word = w;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 in_ready busy", 128'(in_ready), 0);
    quiet("R9 exec");
    @(negedge clk);
    if (kind != 0) begin
      chk("R1 undef", 128'(undef), 128'(kind == 1));
      chk("R6 fault_sp", 128'(fault_sp), 128'(kind == 2));
      chk("R7 fault_align", 128'(fault_align), 128'(kind == 3));
      chk("R7 no write", 128'({mem_valid, wb_valid, done}), 0);
      @(negedge clk);
      chk("R7 back idle", 128'(in_ready), 1);
      quiet("R7 after");
      return;
    end
    for (int g = 0; g < 2; g++) begin
      int st = (g == 0) ? st0 : st1;
      for (int s = 0; s <= st; s++) begin
        mem_ready = (s == st);
        chk("R8 mem_valid", 128'(mem_valid), 1);
        chk(g == 0 ? "R3 addr" : "R8 addr+16", 128'(mem_addr), 128'(acc + 64'(16 * g)));
        chk("R8 tag", 128'(mem_tag), 128'(data[59:56]));
        chk("R8 zero data", mem_wdata, 0);
        chk("R10 no early done", 128'(done), 0);
        @(negedge clk);
      end
      mem_ready = 1'b0;
    end
    chk("R10 done", 128'(done), 1);
    chk("R10 mem idle", 128'(mem_valid), 0);
    chk("R4 wb_valid", 128'(wb_valid), 128'(mode != 2'b10));
    if (mode != 2'b10) begin
      chk("R4 wb_idx", 128'(wb_idx), 128'(n));
      chk("R4 wb_value", 128'(wb_value), 128'(sum));
    end
    @(negedge clk);
    chk("R10 done pulse", 128'(done), 0);
    chk("R9 ready again", 128'(in_ready), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) gpr[i] = 64'hBAD0_0000_0000_0000 | 64'(i);
    gpr[3] = 64'h0000_0000_0000_1000;
    gpr[7] = 64'h0A00_0000_1234_5678;
    gpr[2] = 64'h0000_0000_0000_2000;
    gpr[4] = 64'h0000_0000_0001_0000;
    gpr[5] = 64'h0000_0000_0000_1004;
    gpr[9] = 64'h05F0_FFFF_0000_0000;
    repeat (3) @(negedge clk);
    chk("R9 reset in_ready", 128'(in_ready), 1);
    quiet("R10 reset");
    rst_n = 1'b1;
    @(negedge clk);
    quiet("R10 after reset");

    run_op(enc(9'd5, 2'b10, 5'd3, 5'd7), 0, 0);          // R3 R2 signed offset, no wb (R4)
    run_op(enc(9'h1FF, 2'b11, 5'd2, 5'd9), 2, 1);        // R3 pre-index -16
    run_op(enc(9'h100, 2'b01, 5'd4, 5'd7), 1, 3);        // R2 -4096 post-index
    run_op(enc(9'h0FF, 2'b11, 5'd4, 5'd9), 0, 2);        // R2 +4080 pre-index
    sp_val = 64'h3C00_0000_0000_8000;
    run_op(enc(9'd2, 2'b01, 5'd31, 5'd31), 1, 0);        // R5 SP base and data, wb to 31
    run_op(enc(9'd0, 2'b10, 5'd3, 5'd31), 0, 0);         // R5 data from SP
    sp_val = 64'h3C00_0000_0000_8008;
    run_op(enc(9'd1, 2'b11, 5'd31, 5'd7), 0, 0);         // R6 misaligned SP
    run_op(enc(9'd1, 2'b10, 5'd5, 5'd7), 0, 0);          // R7 misaligned base + offset
    run_op(enc(9'd0, 2'b01, 5'd5, 5'd7), 0, 0);          // R7 post-index misaligned base
    run_op(enc(9'd3, 2'b00, 5'd3, 5'd7), 0, 0);          // R1 mode 00
    run_op(enc(9'd3, 2'b10, 5'd3, 5'd7) ^ 32'h0020_0000, 0, 0); // R1 bad fixed bit
    run_op(enc(9'd1, 2'b00, 5'd31, 5'd7), 0, 0);         // R1 undef beats R6
    sp_val = 64'h0000_0000_0000_4000;
    run_op(enc(9'h1F0, 2'b11, 5'd31, 5'd9), 3, 3);       // R4 pre-index to SP
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule